// File: doc/BRIEF.md
# SDRAM Row Clock-Enable Manager

This block drives the per-row clock-enable (CKE) lines and the per-module clock-pair enables of a main-memory controller. It reads a set of cumulative row-boundary values, works out which rows hold devices, and from that which memory modules are populated. The clock pair of a module with no populated rows is switched off. A new clock-pair setting takes effect only at an edge where no access is in flight, so an active module never sees its clock glitch.

Row power is managed during normal operation. Each time a refresh finishes, every row is dropped into power-down except the row that the oldest pending request needs. When nothing is pending, all rows power down. A powered-down row is woken when the head of the request queue targets it. A ready flag for the head request rises once the row's CKE has been up for a set number of cycles. The command scheduler and the DRAM timing checks sit outside this block.

Top module: `sdram_cke_ctrl`

## Requirements
- R1: Row r is populated when its 8-bit boundary field (bits 8r+7 down to 8r of `row_bnd_i`) differs from the field of row r-1. Row 0 is populated when its field is nonzero.
- R2: The CKE line of an unpopulated row is low in every cycle.
- R3: Clock pair 0 serves rows 0 and 1, and clock pair 1 serves rows 2 and 3. A pair's enable becomes 1 when at least one of its rows is populated and 0 when none is.
- R4: `clk_pair_en_o` changes only one cycle after an edge where `access_busy_i` was low. While busy is high it holds its value.
- R5: After an edge where `refresh_done_i` was high, the CKE of every row is low, except the head row when the head is valid and that row is populated. That row's CKE is high.
- R6: A refresh with no valid head request leaves every CKE low in the following cycle.
- R7: A valid head targeting a populated row raises that row's CKE one cycle later. Rows that are already up stay up until the next refresh.
- R8: `head_ready_o` is high exactly when the head is valid, its row's CKE is high, and that CKE has been high for at least WAKE_CYC consecutive clock edges.
- R9: While reset is active and until it has been synchronized, all CKE lines, both clock-pair enables and the ready flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_bnd_i | input | 32 | Cumulative row-boundary fields, row r in bits 8r+7:8r |
| refresh_done_i | input | 1 | One-cycle pulse when a refresh completes |
| head_valid_i | input | 1 | Oldest pending request is valid |
| head_row_i | input | 2 | Row index of the oldest pending request |
| access_busy_i | input | 1 | A memory access is in flight |
| cke_o | output | 4 | CKE per row |
| clk_pair_en_o | output | 2 | Enable per clock pair (one per module) |
| head_ready_o | output | 1 | Head request's row is awake and settled |

## Verification
The bench builds the block with its defaults: four rows, two rows per module, 8-bit boundaries and WAKE_CYC of 3. These values make the full ready window, including its saturation, reachable within a few cycles. They also let every mix of populated and empty rows and modules be reached by rewriting a few boundary bytes. The stimulus covers the following cases:
- a refresh that arrives while a row is still counting towards ready;
- requests to empty rows;
- a population change held off by a long busy period.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;

  // Width of a counter that must reach the value n.
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Width of an index that selects one of n items.
  function automatic int unsigned idx_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/cke_pop_decode.sv
module cke_pop_decode #(
  parameter int unsigned NUM_ROWS = 4,
  parameter int unsigned BND_W    = 8
) (
  input  logic [NUM_ROWS*BND_W-1:0] bnd_i,
  output logic [NUM_ROWS-1:0]       pop_o
);

  // A row holds devices when its cumulative boundary moves past the row below it.
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    if (r == 0) begin : g_first
      assign pop_o[r] = |bnd_i[BND_W-1:0];
    end else begin : g_rest
      assign pop_o[r] = bnd_i[r*BND_W +: BND_W] != bnd_i[(r-1)*BND_W +: BND_W];
    end
  end

endmodule

// File: rtl/cke_row_slice.sv
module cke_row_slice #(
  parameter int unsigned WAKE_CYC = 3,
  parameter int unsigned CNT_W    = 2
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic pop_i,
  input  logic refresh_i,
  input  logic hit_i,
  output logic cke_o,
  output logic ready_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WAKE_CYC);

  logic             cke_q, cke_n, cke_we;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_we;

  // Next state: refresh keeps only the head row; otherwise a hit wakes the row.
  always_comb begin
    if (refresh_i) begin
      cke_n = hit_i;
    end else begin
      cke_n = cke_q | hit_i;
    end
    cke_n  = cke_n & pop_i;
    cke_we = refresh_i | hit_i | ~pop_i;

    if (!cke_n) begin
      cnt_n = '0;
    end else if (!cke_q) begin
      cnt_n = '0;
    end else if (cnt_q != CNT_TOP) begin
      cnt_n = cnt_q + 1'b1;
    end else begin
      cnt_n = cnt_q;
    end
    cnt_we = (cnt_n != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cke_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (cke_we) cke_q <= cke_n;
      if (cnt_we) cnt_q <= cnt_n;
    end
  end

  assign cke_o   = cke_q & pop_i;
  assign ready_o = cke_o & (cnt_q == CNT_TOP);

  assert_refresh_drop_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (refresh_i && !hit_i) |=> !cke_q);
  assert_refresh_keep_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (refresh_i && hit_i && pop_i) |=> cke_q);
  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (hit_i && pop_i) |=> cke_q);
  assert_ready_settled_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    ready_o |-> (cke_q && $past(cke_q)));
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    cnt_q <= CNT_TOP);

endmodule

// File: rtl/cke_clk_pair_gate.sv
module cke_clk_pair_gate #(
  parameter int unsigned NUM_MODS     = 2,
  parameter int unsigned ROWS_PER_MOD = 2
) (
  input  logic                             clk,
  input  logic                             rst_sn,
  input  logic [NUM_MODS*ROWS_PER_MOD-1:0] pop_i,
  input  logic                             busy_i,
  output logic [NUM_MODS-1:0]              en_o
);

  logic [NUM_MODS-1:0] mod_pop, en_q, en_n;
  logic                en_we;

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
    assign mod_pop[m] = |pop_i[m*ROWS_PER_MOD +: ROWS_PER_MOD];
  end

  always_comb begin
    en_n  = mod_pop;
    en_we = ~busy_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_n;
    end
  end

  assign en_o = en_q;

  assert_hold_busy_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    busy_i |=> $stable(en_o));

endmodule

// File: rtl/sdram_cke_ctrl.sv
module sdram_cke_ctrl
  import sdram_cke_pkg::*;
#(
  parameter int unsigned NUM_ROWS     = 4,
  parameter int unsigned ROWS_PER_MOD = 2,
  parameter int unsigned BND_W        = 8,
  parameter int unsigned WAKE_CYC     = 3
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [NUM_ROWS*BND_W-1:0]                 row_bnd_i,
  input  logic                                      refresh_done_i,
  input  logic                                      head_valid_i,
  input  logic [idx_width(NUM_ROWS)-1:0]            head_row_i,
  input  logic                                      access_busy_i,
  output logic [NUM_ROWS-1:0]                       cke_o,
  output logic [NUM_ROWS/ROWS_PER_MOD-1:0]          clk_pair_en_o,
  output logic                                      head_ready_o
);

  localparam int unsigned NUM_MODS = NUM_ROWS / ROWS_PER_MOD;
  localparam int unsigned ROW_W    = idx_width(NUM_ROWS);
  localparam int unsigned CNT_W    = cnt_width(WAKE_CYC);

  // Reset synchronizer: assert at once, release on the clock.
  logic rst_s1_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_sn   <= rst_s1_q;
    end
  end

  logic [NUM_ROWS-1:0] pop, hit, ready_vec;

  cke_pop_decode #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W)) u_pop (
    .bnd_i (row_bnd_i),
    .pop_o (pop)
  );

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_slice
    assign hit[r] = head_valid_i && (head_row_i == ROW_W'(r));
    cke_row_slice #(.WAKE_CYC(WAKE_CYC), .CNT_W(CNT_W)) u_row (
      .clk       (clk),
      .rst_sn    (rst_sn),
      .pop_i     (pop[r]),
      .refresh_i (refresh_done_i),
      .hit_i     (hit[r]),
      .cke_o     (cke_o[r]),
      .ready_o   (ready_vec[r])
    );
  end

  cke_clk_pair_gate #(.NUM_MODS(NUM_MODS), .ROWS_PER_MOD(ROWS_PER_MOD)) u_gate (
    .clk    (clk),
    .rst_sn (rst_sn),
    .pop_i  (pop),
    .busy_i (access_busy_i),
    .en_o   (clk_pair_en_o)
  );

  assign head_ready_o = head_valid_i & ready_vec[head_row_i];

  assert_unpop_low_R2: assert property (@(posedge clk)
    (cke_o & ~pop) == '0);
  assert_ready_only_head_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    head_ready_o |-> cke_o[head_row_i]);
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_sn |-> (cke_o == '0 && clk_pair_en_o == '0 && !head_ready_o));

endmodule

// File: tb/sim_sdram_cke_ctrl.sv
module sim_sdram_cke_ctrl;

  localparam int W   = 3;
  localparam int PER = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bnd = '0;
  logic        refresh = 1'b0, hv = 1'b0, busy = 1'b0;
  logic [1:0]  hrow = '0;
  logic [3:0]  cke;
  logic [1:0]  cen;
  logic        rdy;

  int total = 0, bad = 0;
  bit done = 0, cmp_on = 0;

  always #(PER/2) clk = ~clk;

  sdram_cke_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .row_bnd_i(bnd), .refresh_done_i(refresh),
    .head_valid_i(hv), .head_row_i(hrow), .access_busy_i(busy),
    .cke_o(cke), .clk_pair_en_o(cen), .head_ready_o(rdy)
  );

  // Behavioural reference model
  bit m_cke[4];
  int m_cnt[4];
  bit [1:0] m_en;
  int rel;

  function automatic bit popd(int r, logic [31:0] b);
    if (r == 0) return b[7:0] != 0;
    return b[r*8 +: 8] != b[(r-1)*8 +: 8];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; m_en = 0;
      foreach (m_cke[i]) begin m_cke[i] = 0; m_cnt[i] = 0; end
    end else if (rel < 2) begin
      rel++;
    end else begin
      for (int i = 0; i < 4; i++) begin
        bit h, n;
        h = hv && (hrow == i);
        n = refresh ? h : (m_cke[i] || h);
        n = n && popd(i, bnd);
        if (!n || !m_cke[i]) m_cnt[i] = 0;
        else if (m_cnt[i] < W) m_cnt[i]++;
        m_cke[i] = n;
      end
      if (!busy) m_en = {popd(2,bnd) || popd(3,bnd), popd(0,bnd) || popd(1,bnd)};
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every clock, a quarter period after the edge.
  always @(posedge clk) begin
    #(PER/4);
    if (cmp_on && !done) begin
      bit [3:0] ec;
      bit er;
      for (int i = 0; i < 4; i++) ec[i] = m_cke[i] && popd(i, bnd);
      er = hv && ec[hrow] && (m_cnt[hrow] == W);
      for (int i = 0; i < 4; i++)
        if (!popd(i, bnd)) chk(cke[i] == 0, "R2 unpopulated cke", cke[i], 0);
      chk(cke == ec, "R5/R7 cke vector", cke, ec);
      chk(cen == m_en, "R3/R4 clock pairs", cen, m_en);
      chk(rdy == er, "R8 head ready", rdy, er);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PER*200000);
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // rows: 0=10, 1=20, 2=20 (empty), 3=40
    bnd = {8'd40, 8'd20, 8'd20, 8'd10};
    tick(2);
    cmp_on = 1;
    chk(cke == 0 && cen == 0 && rdy == 0, "R9 reset state", {cke, cen, rdy}, 0);
    rst_n = 1'b1;
    tick(1);
    chk(cke == 0 && cen == 0, "R9 sync release", {cke, cen}, 0);
    tick(3);
    chk(cen == 2'b11, "R1 R3 both modules populated", cen, 3);

    // Wake row 0 and wait for ready
    hv = 1; hrow = 0;
    tick(1);
    chk(cke == 4'b0001, "R7 wake row 0", cke, 1);
    chk(rdy == 0, "R8 not yet ready", rdy, 0);
    tick(3);
    chk(rdy == 1, "R8 ready after window", rdy, 1);

    // Request to empty row 2
    hrow = 2;
    tick(2);
    chk(cke[2] == 0 && rdy == 0, "R2 R1 empty row stays down", {cke[2], rdy}, 0);

    // Wake row 3; refresh mid-window keeps only row 3
    hrow = 3;
    tick(2);
    chk(cke == 4'b1001, "R7 earlier rows stay up", cke, 9);
    refresh = 1;
    tick(1);
    refresh = 0;
    chk(cke == 4'b1000, "R5 only head row kept", cke, 8);
    tick(2);
    chk(rdy == 1, "R8 head window kept across refresh", rdy, 1);

    // Refresh with nothing pending
    hv = 0; refresh = 1;
    tick(1);
    refresh = 0;
    chk(cke == 0, "R6 all rows down", cke, 0);

    // Refresh with head on empty row
    hv = 1; hrow = 2; refresh = 1;
    tick(1);
    refresh = 0; hv = 0;
    chk(cke == 0, "R5 empty head row not raised", cke, 0);

    // Population change held off by busy
    busy = 1;
    bnd = {8'd20, 8'd20, 8'd20, 8'd0};
    tick(4);
    chk(cen == 2'b11, "R4 held while busy", cen, 3);
    busy = 0;
    tick(1);
    chk(cen == 2'b01, "R3 module 1 gated off", cen, 1);

    // Row 0 now empty, row 1 populated
    hv = 1; hrow = 0;
    tick(2);
    chk(cke == 0, "R1 R2 row 0 empty", cke, 0);
    hrow = 1;
    tick(5);
    chk(cke == 4'b0010 && rdy == 1, "R7 R8 row 1 wake", {cke, rdy}, 5'b00101);

    // Row removed while up: cke drops at once
    bnd = {8'd20, 8'd20, 8'd20, 8'd20};
    tick(1);
    chk(cke == 0 && rdy == 0, "R2 row 1 depopulated", {cke, rdy}, 0);
    hv = 0;
    tick(2);
    chk(cen == 2'b01, "R3 pair 0 still fed by row 0", cen, 1);

    tick(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule